// File: doc/BRIEF.md
# Word-Granular Memory Tag Checker

This block is a small data memory that keeps a 4-bit metadata tag next to every 64-bit word and checks each access against that tag before it is allowed to complete. A processor-side requester issues loads, stores and instruction fetches through a valid/ready request channel. Each access is looked up, checked and answered on a valid/ready response channel after exactly one clock edge. A load or store that the tag does not permit returns an access fault. A fetch of a word flagged as a breakpoint returns a breakpoint indication instead of the instruction.

A separate tag-write port sets the tag of one word per cycle. Privileged software uses it to mark buffers and locals as read/write, constant arguments as read-only, canaries and return-address slots as inaccessible, and any number of code words as breakpoints. The tag encoding is: bit 0 set means readable, bit 1 set means writable, bit 2 set means breakpoint on fetch, and bit 3 is reserved. Access kinds are encoded as 2'b00 load, 2'b01 store, 2'b10 fetch and 2'b11 reserved.

Top module: `tag_checker`

## Requirements
- R1: After reset no response is pending, the request channel is ready, and every tag is 4'b0000, so any load or store faults until a tag is written.
- R2: A load (kind 2'b00) of a word whose tag bit 0 is set returns the word with fault low; if bit 0 is clear it returns fault high and all-zero data.
- R3: A store (kind 2'b01) to a word whose tag bit 1 is set writes the data with fault low; if bit 1 is clear it responds with fault high and neither the word nor its tag changes.
- R4: A fetch (kind 2'b10) ignores tag bits 0 and 1 and never faults; if tag bit 2 is set it raises the breakpoint flag with all-zero data, otherwise it returns the word with the breakpoint flag low.
- R5: Tag bit 3 has no effect on loads, stores or fetches.
- R6: A request accepted on a clock edge produces its response with response valid high right after that same edge.
- R7: While a response is valid and the response-ready input is low, the response fields stay unchanged and the request channel is not ready.
- R8: When the tag-write port writes the same word that a request accepted in that cycle addresses, the access is checked against the newly written tag.
- R9: The reserved kind 2'b11 always responds with fault high and all-zero data and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (64) | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W (64) | Load or fetch data, zero on fault, breakpoint or store |
| rsp_fault | output | 1 | Access fault |
| rsp_brk | output | 1 | Breakpoint on fetch |
| tag_we | input | 1 | Tag write strobe |
| tag_addr | input | ADDR_W (6) | Word whose tag is written |
| tag_wdata | input | TAG_W (4) | New tag value |

## Verification
The bench aims at the cases where a check can quietly leak: a refused store that still writes the array would show the new data on a later permitted load, and a refused load that leaks the word would return non-zero data beside the fault. It retags a word in the same cycle as an access to it, where a design that reads the stale tag would fault a store that should pass or pass a load that should fault. Fetches run against tags with bits 0 and 1 clear and with bit 3 set, which catches a design that applies data permissions or the reserved bit to code. A stalled response with a second request waiting shows whether the block drops or overwrites the held answer.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    localparam int TAG_W   = 4;
    localparam int BIT_RD  = 0;
    localparam int BIT_WR  = 1;
    localparam int BIT_BRK = 2;

    typedef struct packed {
        logic fault;
        logic brk;
        logic wr_en;
        logic pass_data;
    } verdict_t;
endpackage

// File: rtl/tag_store.sv
module tag_store #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [TAG_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [TAG_W-1:0]  rtag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] tags_q [DEPTH];
    logic [TAG_W-1:0] tags_d [DEPTH];

    always_comb begin
        tags_d = tags_q;
        if (we) begin
            tags_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tags_q[i] <= '0;
            end
        end else begin
            tags_q <= tags_d;
        end
    end

    // a tag write in this cycle is seen by the access checked in this cycle
    assign rtag = (we && (waddr == raddr)) ? wdata : tags_q[raddr];

    AST_TAG_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tags_q[$past(waddr)] == $past(wdata))); // R8
endmodule

// File: rtl/access_policy.sv
module access_policy
    import tagchk_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic [1:0]    kind,
    input  logic [TW-1:0] tag,
    output verdict_t      verdict
);
    always_comb begin
        verdict = '0;
        case (acc_kind_e'(kind))
            ACC_LOAD: begin
                verdict.fault     = !tag[BIT_RD];
                verdict.pass_data = tag[BIT_RD];
            end
            ACC_STORE: begin
                verdict.fault = !tag[BIT_WR];
                verdict.wr_en = tag[BIT_WR];
            end
            ACC_FETCH: begin
                verdict.brk       = tag[BIT_BRK];
                verdict.pass_data = !tag[BIT_BRK];
            end
            default: begin
                verdict.fault = 1'b1;
            end
        endcase
    end

    always_comb begin
        AST_VERDICT_EXCL: assert ($countones({verdict.fault, verdict.brk}) <= 1); // R4
    end
endmodule

// File: rtl/data_store.sv
module data_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tag_checker.sv
module tag_checker
    import tagchk_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_fault,
    output logic              rsp_brk,
    input  logic              tag_we,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [TAG_W-1:0]  tag_wdata
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              fault;
        logic              brk;
    } rsp_state_t;

    rsp_state_t        state_d, state_q;
    logic [TAG_W-1:0]  tag_eff;
    logic [DATA_W-1:0] mem_rdata;
    verdict_t          verdict;
    logic              accept;
    logic              mem_we;

    tag_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tag_we),
        .waddr (tag_addr),
        .wdata (tag_wdata),
        .raddr (req_addr),
        .rtag  (tag_eff)
    );

    access_policy #(.TW(TAG_W)) u_policy (
        .kind    (req_kind),
        .tag     (tag_eff),
        .verdict (verdict)
    );

    data_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (req_addr),
        .wdata (req_wdata),
        .raddr (req_addr),
        .rdata (mem_rdata)
    );

    assign req_ready = !state_q.valid || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign mem_we    = accept && verdict.wr_en;

    always_comb begin
        state_d = state_q;
        if (rsp_ready) begin
            state_d.valid = 1'b0;
        end
        if (accept) begin
            state_d.valid = 1'b1;
            state_d.fault = verdict.fault;
            state_d.brk   = verdict.brk;
            state_d.rdata = verdict.pass_data ? mem_rdata : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.valid;
    assign rsp_rdata = state_q.rdata;
    assign rsp_fault = state_q.fault;
    assign rsp_brk   = state_q.brk;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R6
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)
                                       && $stable(rsp_fault) && $stable(rsp_brk))); // R7
    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == '0)); // R2
    AST_WRITE_NEEDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (tag_eff[BIT_WR] && (req_kind == ACC_STORE))); // R3
    AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_kind == ACC_RSVD)) |=> (rsp_fault && !rsp_brk)); // R9
endmodule

// File: tb/tb_tag_checker.sv
module tb_tag_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [5:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_rdata;
    logic        rsp_fault;
    logic        rsp_brk;
    logic        tag_we = 1'b0;
    logic [5:0]  tag_addr = '0;
    logic [3:0]  tag_wdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tag_checker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_fault(rsp_fault), .rsp_brk(rsp_brk),
        .tag_we(tag_we), .tag_addr(tag_addr), .tag_wdata(tag_wdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_tag(input logic [5:0] a, input logic [3:0] t);
        @(negedge clk);
        tag_we = 1'b1; tag_addr = a; tag_wdata = t;
        @(negedge clk);
        tag_we = 1'b0;
    endtask

    // one access; optional concurrent tag write; response sampled one edge later
    task automatic access(input logic [1:0] k, input logic [5:0] a, input logic [63:0] wd,
                          input logic tw, input logic [3:0] tv,
                          output logic [63:0] rd, output logic f, output logic b);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        tag_we = tw; tag_addr = a; tag_wdata = tv;
        @(negedge clk);
        req_valid = 1'b0; tag_we = 1'b0;
        check("R6 rsp_valid after one edge", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata; f = rsp_fault; b = rsp_brk;
    endtask

    task automatic t_reset();
        logic [63:0] rd; logic f, b;
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        access(2'b00, 6'd5, '0, 1'b0, '0, rd, f, b);
        check("R1 load after reset faults", 64'(f), 64'd1);
        access(2'b01, 6'd6, 64'h1234, 1'b0, '0, rd, f, b);
        check("R1 store after reset faults", 64'(f), 64'd1);
    endtask

    task automatic t_load_store();
        logic [63:0] rd; logic f, b;
        set_tag(6'd3, 4'b0011);
        access(2'b01, 6'd3, 64'hA5A5_0000_1111_2222, 1'b0, '0, rd, f, b);
        check("R3 permitted store no fault", 64'(f), 64'd0);
        access(2'b00, 6'd3, '0, 1'b0, '0, rd, f, b);
        check("R2 permitted load data", rd, 64'hA5A5_0000_1111_2222);
        check("R2 permitted load no fault", 64'(f), 64'd0);
        set_tag(6'd3, 4'b0001);
        access(2'b01, 6'd3, 64'hDEAD_BEEF, 1'b0, '0, rd, f, b);
        check("R3 read-only store faults", 64'(f), 64'd1);
        access(2'b00, 6'd3, '0, 1'b0, '0, rd, f, b);
        check("R3 refused store left word", rd, 64'hA5A5_0000_1111_2222);
        check("R3 refused store left tag readable", 64'(f), 64'd0);
        set_tag(6'd4, 4'b0010);
        access(2'b01, 6'd4, 64'h77, 1'b0, '0, rd, f, b);
        check("R3 write-only store ok", 64'(f), 64'd0);
        access(2'b00, 6'd4, '0, 1'b0, '0, rd, f, b);
        check("R2 unreadable load faults", 64'(f), 64'd1);
        check("R2 unreadable load zero data", rd, 64'd0);
    endtask

    task automatic t_fetch();
        logic [63:0] rd; logic f, b;
        set_tag(6'd7, 4'b0011);
        access(2'b01, 6'd7, 64'h0000_0013_0000_0093, 1'b0, '0, rd, f, b);
        set_tag(6'd7, 4'b0000);
        access(2'b10, 6'd7, '0, 1'b0, '0, rd, f, b);
        check("R4 plain fetch data", rd, 64'h0000_0013_0000_0093);
        check("R4 plain fetch no fault", 64'(f), 64'd0);
        check("R4 plain fetch no brk", 64'(b), 64'd0);
        set_tag(6'd7, 4'b0101);
        access(2'b10, 6'd7, '0, 1'b0, '0, rd, f, b);
        check("R4 brk 0101 flag", 64'(b), 64'd1);
        check("R4 brk zero data", rd, 64'd0);
        check("R4 brk no fault", 64'(f), 64'd0);
        set_tag(6'd7, 4'b0100);
        access(2'b10, 6'd7, '0, 1'b0, '0, rd, f, b);
        check("R4 brk 0100 flag", 64'(b), 64'd1);
        access(2'b00, 6'd7, '0, 1'b0, '0, rd, f, b);
        check("R4 brk bit on load not brk", 64'(b), 64'd0);
    endtask

    task automatic t_bit3();
        logic [63:0] rd; logic f, b;
        set_tag(6'd8, 4'b1011);
        access(2'b01, 6'd8, 64'h5555, 1'b0, '0, rd, f, b);
        check("R5 store with bit3", 64'(f), 64'd0);
        access(2'b00, 6'd8, '0, 1'b0, '0, rd, f, b);
        check("R5 load with bit3", rd, 64'h5555);
        set_tag(6'd8, 4'b1000);
        access(2'b00, 6'd8, '0, 1'b0, '0, rd, f, b);
        check("R5 bit3 alone not readable", 64'(f), 64'd1);
        access(2'b10, 6'd8, '0, 1'b0, '0, rd, f, b);
        check("R5 bit3 not brk", 64'(b), 64'd0);
        check("R5 bit3 fetch data", rd, 64'h5555);
    endtask

    task automatic t_forward();
        logic [63:0] rd; logic f, b;
        set_tag(6'd9, 4'b0000);
        access(2'b01, 6'd9, 64'hC0FFEE, 1'b1, 4'b0011, rd, f, b);
        check("R8 store sees new tag", 64'(f), 64'd0);
        access(2'b00, 6'd9, '0, 1'b1, 4'b0000, rd, f, b);
        check("R8 load sees cleared tag", 64'(f), 64'd1);
        set_tag(6'd9, 4'b0001);
        access(2'b00, 6'd9, '0, 1'b0, '0, rd, f, b);
        check("R8 forwarded store wrote", rd, 64'hC0FFEE);
    endtask

    task automatic t_rsvd();
        logic [63:0] rd; logic f, b;
        set_tag(6'd10, 4'b0111);
        access(2'b01, 6'd10, 64'h4242, 1'b0, '0, rd, f, b);
        access(2'b11, 6'd10, 64'h9999, 1'b0, '0, rd, f, b);
        check("R9 reserved faults", 64'(f), 64'd1);
        check("R9 reserved zero data", rd, 64'd0);
        access(2'b00, 6'd10, '0, 1'b0, '0, rd, f, b);
        check("R9 reserved left word", rd, 64'h4242);
    endtask

    task automatic t_backpressure();
        logic [63:0] held;
        set_tag(6'd11, 4'b0011);
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_kind = 2'b00; req_addr = 6'd3;
        @(negedge clk);
        req_addr = 6'd8;
        check("R7 first rsp valid", 64'(rsp_valid), 64'd1);
        held = rsp_rdata;
        check("R7 first rsp data", held, 64'hA5A5_0000_1111_2222);
        check("R7 not ready while stalled", 64'(req_ready), 64'd0);
        @(negedge clk);
        @(negedge clk);
        check("R7 rsp held valid", 64'(rsp_valid), 64'd1);
        check("R7 rsp held data", rsp_rdata, held);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second rsp valid", 64'(rsp_valid), 64'd1);
        check("R7 second rsp is word 8 fault", 64'(rsp_fault), 64'd1);
        @(negedge clk);
        check("R7 drained", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_store();
        t_fetch();
        t_bit3();
        t_forward();
        t_rsvd();
        t_backpressure();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule